// File: doc/BRIEF.md
# Transceiver loopback self-test controller

This controller proves one link transceiver healthy before the transceiver is allowed to carry traffic. Right after reset it closes a loopback path from the transceiver's output logic back to its input logic. On each virtual channel in turn it sends a single bit through a four-phase handshake. It then waits for that bit to come back around the loop, acknowledges it through a second four-phase handshake and compares its value. The pattern on every channel is a 0 and then a 1. The 1 goes out only once the 0 has come back intact. The transceiver counts as failed from reset onward. Only a clean round trip of both bits on every channel moves the controller to its pass state.

One set of test logic serves all virtual channels. A channel index selects which request, acknowledge and data lines the logic drives and watches at any moment. A cycle-count limit, supplied as an input, bounds every wait. Any of these ends the test in a terminal fail state: a wait that runs out, a returned bit with the wrong value, or a receive request on a channel not under test. Only reset leaves a terminal state.

The top-level machine has five states. IDLE is the reset state and moves to ARM on the next clock. ARM closes the loopback for one settling cycle and moves to RUN. RUN tests the channels and moves to PASS after the last channel succeeds, or to FAIL on any error. PASS and FAIL are terminal. A pattern machine with a two-bit state register steps through PAT_IDLE, PAT_ZERO and PAT_ONE for each channel. PAT_ZERO moves to PAT_ONE on a good return. PAT_ONE moves back to PAT_IDLE on a good return. Either state moves back to PAT_IDLE on an error. A handshake engine carries out one transfer with the states HS_IDLE, HS_SEND, HS_SEND_REL, HS_RECV and HS_RECV_REL. Each of these steps forward when its awaited edge arrives. From any of them the engine returns to HS_IDLE on a timeout or a data mismatch.

Top module: `xcvr_loopback_selftest`

## Requirements
- R1: While reset is held, `test_pass`, `test_done`, `loop_en`, every `tx_req` bit and every `rx_ack` bit are 0.
- R2: `loop_en` is 0 in the first cycle after reset release and 1 from the next cycle until a terminal state. No `tx_req` bit is ever high while `loop_en` is 0.
- R3: Each channel gets exactly two transfers, `tx_bit`=0 first and `tx_bit`=1 second. The 1 is sent only after the 0 has returned with value 0.
- R4: A send uses the full four-phase sequence. `tx_req` rises only while that channel's `tx_ack` is low and stays high until `tx_ack` is seen high. `tx_bit` is stable while `tx_req` is high.
- R5: A receive uses the full four-phase sequence. `rx_ack` rises only after `rx_req` on the same channel was seen high. It stays high until `rx_req` is seen low, and then it falls.
- R6: Channels are tested in the order 0, 1, ..., NUM_VC-1. `test_pass` rises only after the last channel's 1 has returned correctly.
- R7: A returned bit (`rx_data` sampled while `rx_req` is high) that differs from the bit sent ends the test in FAIL: `test_done`=1 and `test_pass`=0.
- R8: In every wait, the awaited edge is accepted if it is seen within `timeout_limit`+1 consecutive clock samples. If it is absent for `timeout_limit`+1 consecutive samples, the test ends in FAIL.
- R9: During RUN, a high `rx_req` on any channel other than the one under test ends the test in FAIL.
- R10: PASS and FAIL hold until reset. `test_done` is 1 in both, `test_pass` is 1 only in PASS, and `loop_en`, `tx_req` and `rx_ack` are all 0 in both.
- R11: At most one `tx_req` bit is high at a time, and only on the channel under test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeout_limit | input | CNT_W | Wait limit; a wait fails after this many plus one samples without its edge |
| tx_req | output | NUM_VC | Per-channel send request into the transceiver output logic |
| tx_bit | output | 1 | Test bit presented with the send request |
| tx_ack | input | NUM_VC | Per-channel send acknowledge from the output logic |
| rx_req | input | NUM_VC | Per-channel receive request from the input logic (looped-back bit) |
| rx_data | input | NUM_VC | Per-channel received bit, valid while `rx_req` is high |
| rx_ack | output | NUM_VC | Per-channel receive acknowledge to the input logic |
| loop_en | output | 1 | Closes the transceiver loopback path while the test runs |
| test_done | output | 1 | High in both terminal states |
| test_pass | output | 1 | High only when every channel passed |

## Verification
The handshake assertions take for granted that the transceiver side obeys four-phase order. That means `tx_ack` does not fall while `tx_req` is high, and `rx_req` stays up until `rx_ack` answers it, except where a stuck line is modelled on purpose. The timer's bound assumes `timeout_limit` changes only while reset is held. The bench's responder changes its lines only on falling clock edges, after it has seen the controller's outputs. Its fault knobs break the loop in one controlled way per run: a flipped bit, a dead acknowledge, a stuck request, a late acknowledge or a stray request. The limit is written only during reset.

// File: rtl/lbst_pkg.sv
package lbst_pkg;

    // Top-level test phases
    typedef enum logic [2:0] {
        TOP_IDLE = 3'd0,
        TOP_ARM  = 3'd1,
        TOP_RUN  = 3'd2,
        TOP_PASS = 3'd3,
        TOP_FAIL = 3'd4
    } top_state_e;

    // Two-bit pattern sequencer: which bit of the pair is outstanding
    typedef enum logic [1:0] {
        PAT_IDLE = 2'd0,
        PAT_ZERO = 2'd1,
        PAT_ONE  = 2'd2
    } pat_state_e;

    // One bit round trip: send handshake, then receive handshake
    typedef enum logic [2:0] {
        HS_IDLE     = 3'd0,
        HS_SEND     = 3'd1,
        HS_SEND_REL = 3'd2,
        HS_RECV     = 3'd3,
        HS_RECV_REL = 3'd4
    } hs_state_e;

endpackage

// File: rtl/lbst_timeout.sv
module lbst_timeout #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_i,
    input  logic             event_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Counts samples spent waiting without the awaited edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!wait_i || event_i) begin
            cnt_q <= '0;
        end else if (cnt_q < limit_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        expired_o = wait_i && !event_i && (cnt_q >= limit_i);
    end

    // R8: counter never runs past the limit while the limit is held
    p_count_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(limit_i) |-> (cnt_q <= limit_i));

endmodule

// File: rtl/lbst_handshake.sv
module lbst_handshake
    import lbst_pkg::*;
#(
    parameter int NUM_VC = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill_i,
    input  logic              go_i,
    input  logic              bit_i,
    input  logic [NUM_VC-1:0] ch_mask_i,
    input  logic [CNT_W-1:0]  limit_i,
    input  logic [NUM_VC-1:0] tx_ack_i,
    input  logic [NUM_VC-1:0] rx_req_i,
    input  logic [NUM_VC-1:0] rx_data_i,
    output logic [NUM_VC-1:0] tx_req_o,
    output logic [NUM_VC-1:0] rx_ack_o,
    output logic              tx_bit_o,
    output logic              done_o,
    output logic              err_o
);

    hs_state_e state_q, state_d;
    logic      bit_q;
    logic      sel_tx_ack, sel_rx_req, sel_rx_data;
    logic      waiting, evt, expired, mismatch;

    // Lines of the channel under test
    always_comb begin
        sel_tx_ack  = |(tx_ack_i  & ch_mask_i);
        sel_rx_req  = |(rx_req_i  & ch_mask_i);
        sel_rx_data = |(rx_data_i & ch_mask_i);
    end

    // Awaited edge of the current step
    always_comb begin
        waiting = (state_q != HS_IDLE);
        unique case (state_q)
            HS_SEND:     evt = sel_tx_ack;
            HS_SEND_REL: evt = !sel_tx_ack;
            HS_RECV:     evt = sel_rx_req;
            HS_RECV_REL: evt = !sel_rx_req;
            default:     evt = 1'b0;
        endcase
        mismatch = (state_q == HS_RECV) && sel_rx_req && (sel_rx_data != bit_q);
    end

    lbst_timeout #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_i    (waiting),
        .event_i   (evt),
        .limit_i   (limit_i),
        .expired_o (expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:     if (go_i) state_d = HS_SEND;
            HS_SEND:     if (evt) state_d = HS_SEND_REL;
                         else if (expired) state_d = HS_IDLE;
            HS_SEND_REL: if (evt) state_d = HS_RECV;
                         else if (expired) state_d = HS_IDLE;
            HS_RECV:     if (mismatch) state_d = HS_IDLE;
                         else if (evt) state_d = HS_RECV_REL;
                         else if (expired) state_d = HS_IDLE;
            HS_RECV_REL: if (evt || expired) state_d = HS_IDLE;
            default:     state_d = HS_IDLE;
        endcase
        if (kill_i) state_d = HS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (state_q == HS_IDLE && go_i) begin
            bit_q <= bit_i;
        end
    end

    always_comb begin
        tx_req_o = {NUM_VC{state_q == HS_SEND}} & ch_mask_i;
        rx_ack_o = {NUM_VC{state_q == HS_RECV_REL}} & ch_mask_i;
        tx_bit_o = bit_q;
        done_o   = (state_q == HS_RECV_REL) && evt && !kill_i;
        err_o    = (expired || mismatch) && !kill_i;
    end

    // R11: one send request at most
    p_tx_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_req_o));

    for (genvar g = 0; g < NUM_VC; g++) begin : g_hs_chk
        // R5: receive acknowledge answers a request that was seen
        p_ack_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rx_ack_o[g]) |-> $past(rx_req_i[g]));
        // R4: send request released only after its acknowledge (or on abort)
        p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(tx_req_o[g]) |-> ($past(tx_ack_i[g]) || $past(err_o) || $past(kill_i)));
        // R4: bit stays put during a send request
        p_bit_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_req_o[g] && $past(tx_req_o[g])) |-> $stable(tx_bit_o));
    end

endmodule

// File: rtl/lbst_pattern.sv
module lbst_pattern
    import lbst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kill_i,
    input  logic begin_i,
    input  logic hs_done_i,
    input  logic hs_err_i,
    output logic go_o,
    output logic bit_o,
    output logic ok_o,
    output logic bad_o
);

    pat_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PAT_IDLE: if (begin_i) state_d = PAT_ZERO;
            PAT_ZERO: if (hs_err_i) state_d = PAT_IDLE;
                      else if (hs_done_i) state_d = PAT_ONE;
            PAT_ONE:  if (hs_err_i || hs_done_i) state_d = PAT_IDLE;
            default:  state_d = PAT_IDLE;
        endcase
        if (kill_i) state_d = PAT_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PAT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        go_o  = (state_q == PAT_ZERO) || (state_q == PAT_ONE);
        bit_o = (state_q == PAT_ONE);
        ok_o  = (state_q == PAT_ONE) && hs_done_i && !kill_i;
        bad_o = (state_q != PAT_IDLE) && hs_err_i && !kill_i;
    end

    // R3: the 1 is queued only after the 0 completed its round trip
    p_one_after_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAT_ONE && $past(state_q) != PAT_ONE) |->
            ($past(state_q) == PAT_ZERO && $past(hs_done_i)));

endmodule

// File: rtl/xcvr_loopback_selftest.sv
module xcvr_loopback_selftest
    import lbst_pkg::*;
#(
    parameter int NUM_VC = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  timeout_limit,
    output logic [NUM_VC-1:0] tx_req,
    output logic              tx_bit,
    input  logic [NUM_VC-1:0] tx_ack,
    input  logic [NUM_VC-1:0] rx_req,
    input  logic [NUM_VC-1:0] rx_data,
    output logic [NUM_VC-1:0] rx_ack,
    output logic              loop_en,
    output logic              test_done,
    output logic              test_pass
);

    localparam int              CH_W    = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_VC - 1);

    top_state_e        state_q, state_d;
    logic [CH_W-1:0]   ch_q;
    logic              launch_q;
    logic [NUM_VC-1:0] ch_mask;
    logic              stray, running, kill, begin_pat, advance;
    logic              pat_go, pat_bit, pat_ok, pat_bad;
    logic              hs_done, hs_err;
    logic [NUM_VC-1:0] eng_tx_req, eng_rx_ack;

    for (genvar g = 0; g < NUM_VC; g++) begin : g_mask
        assign ch_mask[g] = (ch_q == CH_W'(g));
    end

    always_comb begin
        running   = (state_q == TOP_RUN);
        kill      = (state_q == TOP_PASS) || (state_q == TOP_FAIL);
        stray     = running && |(rx_req & ~ch_mask);
        advance   = running && pat_ok && !stray && (ch_q != LAST_CH);
        begin_pat = (state_q == TOP_ARM) || launch_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOP_IDLE: state_d = TOP_ARM;
            TOP_ARM:  state_d = TOP_RUN;
            TOP_RUN:  if (pat_bad || stray) state_d = TOP_FAIL;
                      else if (pat_ok && ch_q == LAST_CH) state_d = TOP_PASS;
            TOP_PASS: state_d = TOP_PASS;
            TOP_FAIL: state_d = TOP_FAIL;
            default:  state_d = TOP_FAIL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TOP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Channel index and next-channel launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q     <= '0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= advance;
            if (advance) ch_q <= ch_q + CH_W'(1);
        end
    end

    lbst_pattern u_pattern (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill_i    (kill),
        .begin_i   (begin_pat),
        .hs_done_i (hs_done),
        .hs_err_i  (hs_err),
        .go_o      (pat_go),
        .bit_o     (pat_bit),
        .ok_o      (pat_ok),
        .bad_o     (pat_bad)
    );

    lbst_handshake #(.NUM_VC(NUM_VC), .CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill_i    (kill),
        .go_i      (pat_go),
        .bit_i     (pat_bit),
        .ch_mask_i (ch_mask),
        .limit_i   (timeout_limit),
        .tx_ack_i  (tx_ack),
        .rx_req_i  (rx_req),
        .rx_data_i (rx_data),
        .tx_req_o  (eng_tx_req),
        .rx_ack_o  (eng_rx_ack),
        .tx_bit_o  (tx_bit),
        .done_o    (hs_done),
        .err_o     (hs_err)
    );

    always_comb begin
        tx_req    = eng_tx_req & {NUM_VC{running}};
        rx_ack    = eng_rx_ack & {NUM_VC{running}};
        loop_en   = (state_q == TOP_ARM) || running;
        test_done = kill;
        test_pass = (state_q == TOP_PASS);
    end

    // R10: terminal verdicts hold
    p_pass_terminal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        test_pass |=> (test_pass && test_done));
    p_fail_terminal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (test_done && !test_pass) |=> (test_done && !test_pass));
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |-> (tx_req == '0 && rx_ack == '0 && !loop_en));
    // R6: pass follows a good return of the final bit
    p_pass_from_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_pass) |-> $past(pat_ok));
    // R2: nothing is sent with the loop open
    p_no_tx_unlooped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_req) |-> loop_en);
    // R11: requests only on the channel under test
    p_tx_on_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req & ~ch_mask) == '0);

endmodule

// File: tb/xcvr_loopback_selftest_tb.sv
`timescale 1ns/1ps
module xcvr_loopback_selftest_tb;

    localparam int NV = 3;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] limit = 16'd20;
    logic [NV-1:0] tx_req, rx_ack, tx_ack, rx_req, rx_data;
    logic          tx_bit, loop_en, test_done, test_pass;

    int n_chk = 0, n_bad = 0;
    int ack_delay = 1, flip_ch = -1, flip_bit = -1, dead_ch = -1, stuck_ch = -1;
    bit stray_en = 1'b0;
    int v2 = 0, v4 = 0, v5 = 0, v11 = 0;
    int wcnt [NV];
    bit pend [NV];
    bit pbit [NV];
    int log_ch [16];
    int log_bit [16];
    int nlog = 0;
    logic [NV-1:0] p_tx_req, p_tx_ack, p_rx_ack, p_rx_req;
    logic          p_bit;

    always #10 clk = ~clk;

    xcvr_loopback_selftest #(.NUM_VC(NV), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .timeout_limit(limit),
        .tx_req(tx_req), .tx_bit(tx_bit), .tx_ack(tx_ack),
        .rx_req(rx_req), .rx_data(rx_data), .rx_ack(rx_ack),
        .loop_en(loop_en), .test_done(test_done), .test_pass(test_pass)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    endtask

    // Transceiver model plus protocol monitor, all on falling edges
    task automatic responder();
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                tx_ack = '0; rx_req = '0; rx_data = '0;
                for (int c = 0; c < NV; c++) begin wcnt[c] = 0; pend[c] = 0; pbit[c] = 0; end
            end else begin
                if (!test_done) begin
                    if (!$onehot0(tx_req)) v11++;
                    if ((|tx_req) && !loop_en) v2++;
                    for (int c = 0; c < NV; c++) begin
                        if (tx_req[c] && !p_tx_req[c] && p_tx_ack[c]) v4++;
                        if (!tx_req[c] && p_tx_req[c] && !p_tx_ack[c]) v4++;
                        if (tx_req[c] && p_tx_req[c] && tx_bit != p_bit) v4++;
                        if (rx_ack[c] && !p_rx_ack[c] && !p_rx_req[c]) v5++;
                        if (!rx_ack[c] && p_rx_ack[c] && p_rx_req[c]) v5++;
                    end
                end
                for (int c = 0; c < NV; c++) begin
                    if (tx_req[c] && !tx_ack[c]) begin
                        wcnt[c]++;
                        if (dead_ch != c && wcnt[c] >= ack_delay) begin
                            tx_ack[c] = 1'b1;
                            wcnt[c] = 0;
                            pbit[c] = tx_bit ^ (flip_ch == c && flip_bit == int'(tx_bit));
                            pend[c] = 1'b1;
                            if (nlog < 16) begin
                                log_ch[nlog] = c; log_bit[nlog] = int'(tx_bit);
                            end
                            nlog++;
                            if (stray_en && nlog == 1) rx_req[NV-1] = 1'b1;
                        end
                    end else if (!tx_req[c] && tx_ack[c]) begin
                        tx_ack[c] = 1'b0;
                    end
                    if (rx_req[c] && rx_ack[c] && stuck_ch != c) begin
                        rx_req[c] = 1'b0;
                    end else if (pend[c] && !rx_req[c] && !rx_ack[c]) begin
                        rx_req[c] = 1'b1; rx_data[c] = pbit[c]; pend[c] = 1'b0;
                    end
                end
            end
            p_tx_req = tx_req; p_tx_ack = tx_ack; p_rx_ack = rx_ack;
            p_rx_req = rx_req; p_bit = tx_bit;
        end
    endtask

    task automatic start_run(input int lim, input bit check_reset);
        rst_n = 1'b0;
        limit = CW'(lim);
        v2 = 0; v4 = 0; v5 = 0; v11 = 0; nlog = 0;
        repeat (3) @(negedge clk);
        if (check_reset) begin
            chk("R1", int'(test_pass), 0, "pass in reset");
            chk("R1", int'(test_done), 0, "done in reset");
            chk("R1", int'(loop_en), 0, "loop_en in reset");
            chk("R1", int'(tx_req), 0, "tx_req in reset");
            chk("R1", int'(rx_ack), 0, "rx_ack in reset");
        end
        rst_n = 1'b1;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!test_done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic clear_knobs();
        ack_delay = 1; flip_ch = -1; flip_bit = -1; dead_ch = -1;
        stuck_ch = -1; stray_en = 1'b0;
    endtask

    task automatic check_protocol(input string tag);
        chk("R2", v2, 0, {tag, " tx_req with loop open"});
        chk("R4", v4, 0, {tag, " send handshake order"});
        chk("R5", v5, 0, {tag, " receive handshake order"});
        chk("R11", v11, 0, {tag, " multiple tx_req"});
    endtask

    task automatic check_terminal(input int exp_pass);
        repeat (10) @(negedge clk);
        chk("R10", int'(test_done), 1, "done held");
        chk("R10", int'(test_pass), exp_pass, "verdict held");
        chk("R10", int'(loop_en), 0, "loop_en in terminal");
        chk("R10", int'(tx_req | rx_ack), 0, "handshake lines quiet in terminal");
    endtask

    task automatic t_clean();
        int cyc, bad_order;
        clear_knobs();
        start_run(20, 1'b1);
        chk("R2", int'(loop_en), 0, "loop_en first cycle");
        @(negedge clk);
        chk("R2", int'(loop_en), 1, "loop_en after arm");
        wait_done(cyc);
        chk("R6", int'(test_pass), 1, "clean loop passes");
        chk("R6", nlog, 2 * NV, "transfer count");
        bad_order = 0;
        for (int k = 0; k < 2 * NV; k++)
            if (log_ch[k] != k / 2 || log_bit[k] != k % 2) bad_order++;
        chk("R3", bad_order, 0, "channel and bit order");
        check_protocol("clean");
        check_terminal(1);
    endtask

    task automatic t_bad_data(input int ch, input int b);
        int cyc, ones;
        clear_knobs();
        flip_ch = ch; flip_bit = b;
        start_run(20, 1'b0);
        wait_done(cyc);
        chk("R7", int'(test_done), 1, "done after corrupt bit");
        chk("R7", int'(test_pass), 0, "no pass after corrupt bit");
        chk("R3", nlog, 2 * ch + b + 1, "transfers stop at corrupt bit");
        ones = 0;
        for (int k = 0; k < nlog && k < 16; k++)
            if (log_ch[k] == ch && log_bit[k] == 1) ones++;
        chk("R3", ones, b, "bit 1 sent only after good 0");
        check_protocol("corrupt");
        check_terminal(0);
    endtask

    task automatic t_dead_ack();
        int cyc;
        clear_knobs();
        dead_ch = 1;
        start_run(8, 1'b0);
        wait_done(cyc);
        chk("R8", int'(test_done && !test_pass), 1, "dead acknowledge fails");
        chk("R8", int'(cyc < 60), 1, "timeout bounded");
        chk("R8", nlog, 2, "no transfer past dead channel");
        check_protocol("dead");
    endtask

    task automatic t_stuck_rx();
        int cyc;
        clear_knobs();
        stuck_ch = 0;
        start_run(8, 1'b0);
        wait_done(cyc);
        chk("R5", int'(test_done && !test_pass), 1, "stuck rx_req fails");
        chk("R5", nlog, 1, "stops at first return");
        check_protocol("stuck");
    endtask

    task automatic t_delay(input int d, input int exp_pass);
        int cyc;
        clear_knobs();
        ack_delay = d;
        start_run(5, 1'b0);
        wait_done(cyc);
        chk("R8", int'(test_done), 1, "delay run finishes");
        chk("R8", int'(test_pass), exp_pass, "ack after delay vs limit 5");
        check_protocol("delay");
    endtask

    task automatic t_stray();
        int cyc;
        clear_knobs();
        stray_en = 1'b1;
        start_run(20, 1'b0);
        wait_done(cyc);
        chk("R9", int'(test_done && !test_pass), 1, "stray request fails");
        chk("R9", nlog, 1, "stopped at stray");
        check_terminal(0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        tx_ack = '0; rx_req = '0; rx_data = '0;
        p_tx_req = '0; p_tx_ack = '0; p_rx_ack = '0; p_rx_req = '0; p_bit = 1'b0;
        fork
            responder();
        join_none
        t_clean();
        t_bad_data(1, 0);
        t_bad_data(2, 1);
        t_dead_ack();
        t_stuck_rx();
        t_delay(6, 1);
        t_delay(7, 0);
        t_stray();
        summary();
        $finish;
    end

endmodule